// File: doc/BRIEF.md
# Byte-Lane Access Attribute Checker

This block guards one 32-bit register word on a simple single-cycle bus. Each request carries a read/write flag, byte enables and two requester qualifiers (privileged, secure). The checker holds one 8-bit attribute field per byte lane. For every lane the request enables, it decides from that lane's field whether the requester's class may read or write it.

A request is forwarded to the protected word only when every enabled lane permits it. Otherwise the write is dropped, the read returns zero and an error response is raised. The attribute word is loaded through a separate configuration input, which is not itself subject to the check.

Each field holds a three-bit permission level and a bypass bit. The levels form a ladder that strips rights first from nonsecure requesters, then from user secure requesters, and last from privileged secure requesters. Decision, forwarding and response are registered, so all of them appear one clock after the request.

Top module: `lane_guard`

## Requirements
- R1: A synchronous active-high reset clears the attribute word to zero (every lane fully open) and drives rsp_valid and fwd_valid low on the following clock.
- R2: Attribute field i occupies cfg_attr bits [8i+7:8i] and governs lane i, which is byte enable bit i and data bits [8i+7:8i]. The requester class is decoded as follows: req_secure=0 is user nonsecure whatever req_priv is; req_secure=1 with req_priv=0 is user secure; req_secure=1 with req_priv=1 is privileged secure.
- R3: Field bits [2:0] give the permission level, listed as nonsecure / user secure / privileged secure. Level 0 is RW/RW/RW. Level 1 is R/RW/RW. Level 2 is none/RW/RW. Level 3 is R/R/RW. Level 4 is none/R/RW. Level 5 is none/none/RW. Level 6 is none/none/R. Level 7 is none/none/none.
- R4: Field bit 7 set makes the lane permit any access regardless of level. Field bits [6:3] have no effect.
- R5: A request is allowed only if every lane whose byte enable is set permits it. Lanes with a clear byte enable are not judged, so a request with no enables is allowed.
- R6: An allowed request produces, one clock later, fwd_valid=1 with fwd_write, fwd_be and fwd_wdata copied from the request, plus rsp_valid=1 and rsp_err=0. For a read, rsp_rdata equals tgt_rdata with the non-enabled lanes zeroed. For a write, rsp_rdata is zero.
- R7: A denied request produces, one clock later, fwd_valid=0, rsp_valid=1, rsp_err=1 and rsp_rdata=0.
- R8: A configuration load and a request in the same cycle: the request is judged against the attribute word held before the load, and the loaded value governs the following requests.
- R9: A cycle without req_valid gives rsp_valid=0 and fwd_valid=0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load the attribute word |
| cfg_attr | input | 32 | New attribute word, one 8-bit field per lane |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Requester is privileged |
| req_secure | input | 1 | Requester is secure |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| tgt_rdata | input | 32 | Read data from the protected word |
| fwd_valid | output | 1 | Access forwarded to the protected word |
| fwd_write | output | 1 | Forwarded access is a write |
| fwd_be | output | 4 | Forwarded byte enables |
| fwd_wdata | output | 32 | Forwarded write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access was denied |
| rsp_rdata | output | 32 | Read data returned to the requester |

## Verification
A configuration load and a checked request can land on the same clock edge. This happens when software tightens or relaxes a lane while traffic is flowing. The bench provokes it by loading level 7 into every lane in the very cycle an open-lane write is presented, and then repeating the write. The first write must be forwarded without error against the old word, and the repeat must be refused. Relaxing a locked lane in the same way must likewise leave the colliding request denied and let the following one through.

// File: rtl/lg_pkg.sv
package lg_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    CLS_USER_NS  = 2'd0,
    CLS_USER_S   = 2'd1,
    CLS_PRIV_S   = 2'd2
  } req_class_e;

  // bit n of each mask = level n grants the right
  localparam logic [7:0] RD_USER_NS = 8'b0000_1011;
  localparam logic [7:0] WR_USER_NS = 8'b0000_0001;
  localparam logic [7:0] RD_USER_S  = 8'b0001_1111;
  localparam logic [7:0] WR_USER_S  = 8'b0000_0111;
  localparam logic [7:0] RD_PRIV_S  = 8'b0111_1111;
  localparam logic [7:0] WR_PRIV_S  = 8'b0011_1111;

  function automatic req_class_e class_of(input logic priv, input logic secure);
    if (!secure)    return CLS_USER_NS;
    else if (!priv) return CLS_USER_S;
    else            return CLS_PRIV_S;
  endfunction

endpackage

// File: rtl/lg_attr_reg.sv
module lg_attr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/lg_lane_perm.sv
module lg_lane_perm
  import lg_pkg::*;
#(
  parameter int ATTR_W = 8
) (
  input  logic [ATTR_W-1:0] field,
  input  req_class_e        cls,
  input  logic              write,
  output logic              grant
);
  logic [CODE_W-1:0] level;
  logic              bypass;
  logic [7:0]        rights;

  assign level  = field[CODE_W-1:0];
  assign bypass = field[ATTR_W-1];

  always_comb begin
    unique case (cls)
      CLS_USER_NS: rights = write ? WR_USER_NS : RD_USER_NS;
      CLS_USER_S:  rights = write ? WR_USER_S  : RD_USER_S;
      default:     rights = write ? WR_PRIV_S  : RD_PRIV_S;
    endcase
    grant = bypass | rights[level];
  end
endmodule

// File: rtl/lane_guard.sv
module lane_guard
  import lg_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int ATTR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [LANES*ATTR_W-1:0]   cfg_attr,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic                      req_priv,
  input  logic                      req_secure,
  input  logic [LANES-1:0]          req_be,
  input  logic [LANES*LANE_W-1:0]   req_wdata,
  input  logic [LANES*LANE_W-1:0]   tgt_rdata,
  output logic                      fwd_valid,
  output logic                      fwd_write,
  output logic [LANES-1:0]          fwd_be,
  output logic [LANES*LANE_W-1:0]   fwd_wdata,
  output logic                      rsp_valid,
  output logic                      rsp_err,
  output logic [LANES*LANE_W-1:0]   rsp_rdata
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int CFG_W  = LANES * ATTR_W;

  logic [CFG_W-1:0]  attr_q;
  logic [LANES-1:0]  lane_grant;
  logic [LANES-1:0]  lane_ok;
  logic              allow;
  req_class_e        cls;
  logic              rd_q;
  logic [DATA_W-1:0] byte_mask;

  lg_attr_reg #(.W(CFG_W)) u_attr (
    .clk (clk),
    .rst (rst),
    .we  (cfg_we),
    .d   (cfg_attr),
    .q   (attr_q)
  );

  assign cls = class_of(req_priv, req_secure);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lg_lane_perm #(.ATTR_W(ATTR_W)) u_perm (
      .field (attr_q[i*ATTR_W +: ATTR_W]),
      .cls   (cls),
      .write (req_write),
      .grant (lane_grant[i])
    );
    assign lane_ok[i] = ~req_be[i] | lane_grant[i];
    assign byte_mask[i*LANE_W +: LANE_W] = {LANE_W{fwd_be[i]}};
  end

  assign allow = &lane_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_write <= 1'b0;
      fwd_be    <= '0;
      fwd_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rd_q      <= 1'b0;
    end else begin
      fwd_valid <= req_valid & allow;
      fwd_write <= req_valid & allow & req_write;
      fwd_be    <= req_be;
      fwd_wdata <= req_wdata;
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & ~allow;
      rd_q      <= req_valid & allow & ~req_write;
    end
  end

  assign rsp_rdata = rd_q ? (tgt_rdata & byte_mask) : '0;
endmodule

// File: rtl/lg_checker.sv
module lg_checker #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int ATTR_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic [LANES*ATTR_W-1:0] attr_q,
  input logic                    fwd_valid,
  input logic                    rsp_valid,
  input logic                    rsp_err,
  input logic [LANES*LANE_W-1:0] rsp_rdata
);
  logic all_bypass;
  always_comb begin
    all_bypass = 1'b1;
    for (int i = 0; i < LANES; i++)
      all_bypass = all_bypass & attr_q[i*ATTR_W + ATTR_W - 1];
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !fwd_valid));

  a_r9_no_req_no_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !fwd_valid));

  a_r6_req_gets_rsp: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r7_deny_blocks: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (!fwd_valid && rsp_rdata == '0));

  a_r6_fwd_is_clean: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (rsp_valid && !rsp_err));

  a_r4_bypass_all: assert property (@(posedge clk) disable iff (rst)
    (req_valid && all_bypass) |=> (rsp_valid && !rsp_err));
endmodule

bind lane_guard lg_checker #(.LANES(LANES), .LANE_W(LANE_W), .ATTR_W(ATTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .attr_q    (attr_q),
  .fwd_valid (fwd_valid),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/sim_lane_guard.sv
`timescale 1ns/1ps
module sim_lane_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_attr = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0, req_secure = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] tgt_rdata = 32'hA1B2_C3D4;
  logic        fwd_valid, fwd_write, rsp_valid, rsp_err;
  logic [3:0]  fwd_be;
  logic [31:0] fwd_wdata, rsp_rdata;

  always #2.5 clk = ~clk;

  lane_guard u0 (.*);

  typedef struct {
    bit          rv, err, fv, fw;
    logic [3:0]  fbe;
    logic [31:0] fwd, rd;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          total = 0, bad = 0;
  logic [31:0] shadow = '0;
  bit          ns_priv = 1'b0;
  bit          done = 1'b0;

  // independent permission model: 0 = user nonsecure, 1 = user secure, 2 = privileged secure
  function automatic bit lane_ok(logic [7:0] f, int cls, bit wr);
    if (f[7]) return 1'b1;
    case (f[2:0])
      3'd0: return 1'b1;
      3'd1: return (cls != 0) || !wr;
      3'd2: return cls != 0;
      3'd3: return (cls == 2) || !wr;
      3'd4: return (cls == 2) || (cls == 1 && !wr);
      3'd5: return cls == 2;
      3'd6: return (cls == 2) && !wr;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(bit we, logic [31:0] av, bit v, bit wr, int cls,
                       logic [3:0] be, logic [31:0] wd, string tag);
    exp_t e;
    bit ok = 1'b1;
    logic [31:0] m = '0;
    @(negedge clk);
    cfg_we = we; cfg_attr = av;
    req_valid = v; req_write = wr; req_be = be; req_wdata = wd;
    if (cls == 0) begin req_secure = 1'b0; ns_priv = ~ns_priv; req_priv = ns_priv; end
    else begin req_secure = 1'b1; req_priv = (cls == 2); end
    for (int i = 0; i < 4; i++) begin
      if (be[i] && !lane_ok(shadow[i*8 +: 8], cls, wr)) ok = 1'b0;
      if (be[i]) m[i*8 +: 8] = 8'hFF;
    end
    e.rv = v; e.err = v && !ok; e.fv = v && ok; e.fw = wr;
    e.fbe = be; e.fwd = wd; e.rd = (v && ok && !wr) ? (tgt_rdata & m) : 32'h0;
    e.tag = tag;
    q.push_back(e);
    if (we) shadow = av;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        bit mis;
        e = q.pop_front();
        total++;
        mis = (rsp_valid !== e.rv) || (fwd_valid !== e.fv);
        if (e.rv) mis = mis || (rsp_err !== e.err) || (rsp_rdata !== e.rd);
        if (e.fv) mis = mis || (fwd_write !== e.fw) || (fwd_be !== e.fbe) || (fwd_wdata !== e.fwd);
        if (mis) begin
          bad++;
          $display("FAIL %s: got rv=%0b err=%0b fv=%0b fw=%0b be=%h wd=%h rd=%h exp rv=%0b err=%0b fv=%0b fw=%0b be=%h wd=%h rd=%h",
                   e.tag, rsp_valid, rsp_err, fwd_valid, fwd_write, fwd_be, fwd_wdata, rsp_rdata,
                   e.rv, e.err, e.fv, e.fw, e.fbe, e.fwd, e.rd);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || fwd_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: got rv=%0b fv=%0b exp 0 0", rsp_valid, fwd_valid);
    end
    rst = 1'b0;
    // R1: attribute word zero after reset, so every class may write all lanes
    drive(0, 0, 1, 1, 0, 4'hF, 32'h1111_2222, "R1");
    drive(0, 0, 1, 0, 0, 4'hF, 32'h0, "R1");
    // R9: idle cycles
    drive(0, 0, 0, 0, 0, 4'h0, 32'h0, "R9");
    drive(0, 0, 0, 1, 2, 4'hF, 32'hFFFF_FFFF, "R9");
    // R3: full ladder, one lane at a time
    for (int code = 0; code < 8; code++) begin
      drive(1, {4{code[7:0]}}, 0, 0, 0, 4'h0, 32'h0, "R3");
      for (int cls = 0; cls < 3; cls++)
        for (int wr = 0; wr < 2; wr++)
          drive(0, 0, 1, wr[0], cls, 4'b1 << (code % 4), 32'hC0DE_0000 + code, "R3");
    end
    // R2: lane mapping, only lane 1 open
    drive(1, 32'h0707_0007, 0, 0, 0, 4'h0, 32'h0, "R2");
    drive(0, 0, 1, 0, 0, 4'b0010, 32'h0, "R2");
    drive(0, 0, 1, 0, 2, 4'b0001, 32'h0, "R2");
    drive(0, 0, 1, 1, 2, 4'b0100, 32'h0, "R2");
    drive(0, 0, 1, 1, 1, 4'b0010, 32'h5555_AAAA, "R2");
    // R2: privileged nonsecure behaves as user nonsecure (level 1: read only)
    drive(1, 32'h0101_0101, 0, 0, 0, 4'h0, 32'h0, "R2");
    for (int k = 0; k < 2; k++) begin
      drive(0, 0, 1, 1, 0, 4'hF, 32'h1, "R2");
      drive(0, 0, 1, 0, 0, 4'hF, 32'h0, "R2");
    end
    // R4: bypass bit and ignored middle bits
    drive(1, 32'h8707_8707, 0, 0, 0, 4'h0, 32'h0, "R4");
    drive(0, 0, 1, 1, 0, 4'b0101, 32'h0BAD_F00D, "R4");
    drive(0, 0, 1, 1, 0, 4'b0010, 32'h0, "R4");
    drive(1, 32'h7F7F_7F7F, 0, 0, 0, 4'h0, 32'h0, "R4");
    drive(0, 0, 1, 0, 2, 4'b1000, 32'h0, "R4");
    drive(1, 32'h7878_7878, 0, 0, 0, 4'h0, 32'h0, "R4");
    drive(0, 0, 1, 1, 0, 4'hF, 32'h0, "R4");
    drive(1, 32'hFFFF_FFFF, 0, 0, 0, 4'h0, 32'h0, "R4");
    drive(0, 0, 1, 1, 0, 4'hF, 32'hFEED_BEEF, "R4");
    // R5: mixed lanes and empty enables
    drive(1, 32'h0500_0300, 0, 0, 0, 4'h0, 32'h0, "R5");
    drive(0, 0, 1, 0, 1, 4'b0011, 32'h0, "R5");
    drive(0, 0, 1, 1, 1, 4'b0011, 32'h0, "R5");
    drive(0, 0, 1, 1, 1, 4'b1001, 32'h0, "R5");
    drive(0, 0, 1, 1, 2, 4'b1111, 32'h1234_5678, "R5");
    drive(1, 32'h0707_0707, 0, 0, 0, 4'h0, 32'h0, "R5");
    drive(0, 0, 1, 1, 2, 4'b0000, 32'h0, "R5");
    drive(0, 0, 1, 0, 2, 4'b0100, 32'h0, "R7");
    // R8: load colliding with a request, both directions
    drive(1, 32'h0000_0000, 0, 0, 0, 4'h0, 32'h0, "R8");
    drive(1, 32'h0707_0707, 1, 1, 0, 4'hF, 32'hAAAA_0001, "R8");
    drive(0, 0, 1, 1, 0, 4'hF, 32'hAAAA_0002, "R8");
    drive(1, 32'h0000_0000, 1, 0, 2, 4'hF, 32'h0, "R8");
    drive(0, 0, 1, 0, 2, 4'hF, 32'h0, "R8");
    // R6/R7: partial read data masking and denial data
    drive(0, 0, 1, 0, 0, 4'b1010, 32'h0, "R6");
    drive(1, 32'h0600_0000, 0, 0, 0, 4'h0, 32'h0, "R7");
    drive(0, 0, 1, 0, 1, 4'b1001, 32'h0, "R7");
    drive(0, 0, 0, 0, 0, 4'h0, 32'h0, "R9");
    repeat (3) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R6: got %0d pending responses exp 0", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule